// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel of a general-purpose timer. An asynchronous pin enters a two-stage synchronizer and then a digital filter. The filter only accepts a new level once that level has been seen on two consecutive clock samples. A registered edge detector compares the accepted level with its previous value. When the detected transition matches the selected polarity, the channel copies the free-running count into its capture register and sets a status flag. An interrupt request is raised while the flag is set and interrupts are enabled.

The count, the prescaler and the register decoding live outside the block. Several channels can share one count bus. Each channel has its own pin, control inputs and outputs, and the channels do not interact.

The path from pin to capture has a fixed depth. A pin level first sampled at clock edge k is reflected in the flag and the capture register right after edge k+4. The stored count is the value presented on the count bus at that edge.

Top module: `tcap_channel`

## Requirements
- R1: The edge-select input chooses the capturing transition: 2'b01 captures rising edges only, 2'b10 falling edges only, and 2'b11 both. 2'b00 turns capture off, so no transition sets the flag or changes the capture register.
- R2: On a capture the register loads the count value present at the capturing clock edge. Each later capture overwrites it.
- R3: A capture sets the flag. A one-cycle clear strobe drops the flag at the next edge. If a capture and a clear land on the same edge, the capture wins and the flag stays set.
- R4: The interrupt request is high only while the flag and the interrupt enable are both high. With the enable low, the flag is still set by a capture.
- R5: A pin pulse that no clock edge samples has no effect. A pulse seen at only one sampling edge is also rejected by the filter.
- R6: A new level held for two or more consecutive sampling edges is always accepted and produces a capture when it matches the selection.
- R7: A pin change first sampled at edge k sets the flag and loads the register at edge k+4 and not earlier.
- R8: Outside captures, the capture register keeps its value. Outside captures and clears, the flag keeps its value. Reading the outputs changes nothing.
- R9: Reset clears the capture register, the flag and all synchronizer, filter and detector state. A pin held high through reset and after it does not produce a capture.
- R10: Channels work independently on a shared count. Two channels whose pins change before the same edge store identical counts. A one-cycle skew between their pins gives stored values that differ by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Free-running timer count |
| edge_sel_i | input | 2 | Capture polarity: 00 off, 01 rising, 10 falling, 11 both |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_val_o | output | CNT_W | Captured count |
| flag_o | output | 1 | Capture status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the filter boundary with three pulses: one that falls between clock edges, one that is sampled once, and one that is sampled twice. A filter one sample too short would capture the single-sample pulse, and one sample too long would miss the two-sample pulse. The bench times the exact four-edge latency, so a missing or extra pipeline stage shows up as a wrong flag timing and a wrong stored count. It also lands a clear strobe on the capture edge, where a clear-priority flag would drop a real event. Finally, it holds the pin high through reset, where a filter that trusts its reset contents would report a false rising edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic [1:0] {
      TCAP_OFF  = 2'b00,
      TCAP_RISE = 2'b01,
      TCAP_FALL = 2'b10,
      TCAP_ANY  = 2'b11
   } tcap_sel_e;
endpackage

// File: rtl/tcap_sync.sv
// Multi-stage synchronizer with a parallel valid pipeline so that
// reset contents are never mistaken for sampled pin levels.
module tcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic vld_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] dq;
   logic [STAGES-1:0] vq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq <= '0;
         vq <= '0;
      end else begin
         dq <= {dq[STAGES-2:0], d_i};
         vq <= {vq[STAGES-2:0], 1'b1};
      end
   end

   assign q_o   = dq[STAGES-1];
   assign vld_o = vq[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
// Agreement filter: a level is accepted once LEN consecutive valid
// samples agree on it.
module tcap_filter #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic vld_i,
   output logic lvl_o,
   output logic vld_o
);
   localparam int HW = LEN - 1;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("tcap_filter: LEN must be at least 2");
      end
   endgenerate

   logic [HW-1:0] hist_d;
   logic [HW-1:0] hist_v;
   logic          agree;

   generate
      if (HW == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_d <= '0;
               hist_v <= '0;
            end else begin
               hist_d <= lvl_i;
               hist_v <= vld_i;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_d <= '0;
               hist_v <= '0;
            end else begin
               hist_d <= {hist_d[HW-2:0], lvl_i};
               hist_v <= {hist_v[HW-2:0], vld_i};
            end
         end
      end
   endgenerate

   assign agree = (&{hist_v, vld_i}) &&
                  ((&{hist_d, lvl_i}) || !(|{hist_d, lvl_i}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_o <= 1'b0;
         vld_o <= 1'b0;
      end else if (agree) begin
         lvl_o <= lvl_i;
         vld_o <= 1'b1;
      end
   end
endmodule

// File: rtl/tcap_edge.sv
// Registered transition detector with polarity selection. The first
// accepted level after reset only primes the detector.
module tcap_edge
   import tcap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_i,
   input  logic      vld_i,
   input  tcap_sel_e sel_i,
   output logic      hit_o
);
   logic prev_lvl;
   logic prev_vld;
   logic moved;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b0;
         prev_vld <= 1'b0;
      end else begin
         prev_lvl <= lvl_i;
         prev_vld <= vld_i;
      end
   end

   assign moved = vld_i && prev_vld && (lvl_i != prev_lvl);
   assign rise  = moved && lvl_i;
   assign fall  = moved && !lvl_i;

   always_comb begin
      unique case (sel_i)
         TCAP_RISE: hit_o = rise;
         TCAP_FALL: hit_o = fall;
         TCAP_ANY:  hit_o = rise || fall;
         default:   hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
   import tcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [1:0]       edge_sel_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             flag_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("tcap_channel: CNT_W must be positive");
      end
   endgenerate

   logic             sync_lvl;
   logic             sync_vld;
   logic             filt_lvl;
   logic             filt_vld;
   logic             cap_hit;
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;

   tcap_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (sync_lvl),
      .vld_o (sync_vld)
   );

   tcap_filter #(.LEN(FILT_LEN)) filt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_lvl),
      .vld_i (sync_vld),
      .lvl_o (filt_lvl),
      .vld_o (filt_vld)
   );

   tcap_edge edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (filt_lvl),
      .vld_i (filt_vld),
      .sel_i (tcap_sel_e'(edge_sel_i)),
      .hit_o (cap_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (cap_hit) begin
         cap_q <= count_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (cap_hit) begin
         flag_q <= 1'b1;
      end else if (flag_clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign cap_val_o = cap_q;
   assign flag_o    = flag_q;
   assign irq_o     = flag_q & irq_en_i;
endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic [1:0]       edge_sel_i,
   input logic             irq_en_i,
   input logic             flag_clr_i,
   input logic [CNT_W-1:0] cap_val_o,
   input logic             flag_o,
   input logic             irq_o,
   input logic             hit
);
   a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en_i);

   a_r2_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit) |-> (cap_val_o == $past(count_i)));

   a_r3_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit) |-> flag_o);

   a_r3_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_clr_i) && !$past(hit)) |-> !flag_o);

   a_r8_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hit) |-> $stable(cap_val_o));

   a_r1_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel_i == 2'b00) |-> !hit);
endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .count_i    (count_i),
   .edge_sel_i (edge_sel_i),
   .irq_en_i   (irq_en_i),
   .flag_clr_i (flag_clr_i),
   .cap_val_o  (cap_val_o),
   .flag_o     (flag_o),
   .irq_o      (irq_o),
   .hit        (cap_hit)
);

// File: tb/tcap_channel_tb_top.sv
module tcap_channel_tb_top;
   localparam int PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt = '0;
   logic        pin_a = 1'b0, pin_b = 1'b0;
   logic [1:0]  sel_a = 2'b01, sel_b = 2'b01;
   logic        ien_a = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
   logic [15:0] cap_a, cap_b;
   logic        flag_a, flag_b, irq_a, irq_b;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #(PER/2) clk = ~clk;

   tcap_channel dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_a), .count_i(cnt),
      .edge_sel_i(sel_a), .irq_en_i(ien_a), .flag_clr_i(clr_a),
      .cap_val_o(cap_a), .flag_o(flag_a), .irq_o(irq_a));

   tcap_channel dut_b_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_b), .count_i(cnt),
      .edge_sel_i(sel_b), .irq_en_i(1'b0), .flag_clr_i(clr_b),
      .cap_val_o(cap_b), .flag_o(flag_b), .irq_o(irq_b));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
      cnt = cnt + 16'd1;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic clear_a();
      clr_a = 1'b1;
      tick();
      clr_a = 1'b0;
   endtask

   // behavioural reference model for channel A
   bit          smp_q[$];
   bit          m_vld, m_lvl, m_flag;
   logic [15:0] m_cap;

   always @(posedge clk) begin
      bit hit;
      hit = 1'b0;
      if (!rst_n) begin
         smp_q.delete();
         m_vld = 0; m_lvl = 0; m_flag = 0; m_cap = '0;
      end else begin
         smp_q.push_back(pin_a);
         if (smp_q.size() > 5) void'(smp_q.pop_front());
         if (smp_q.size() == 5 && smp_q[0] == smp_q[1]) begin
            if (!m_vld) begin
               m_vld = 1; m_lvl = smp_q[0];
            end else if (smp_q[0] != m_lvl) begin
               hit = smp_q[0] ? sel_a[0] : sel_a[1];
               m_lvl = smp_q[0];
            end
         end
         if (hit) begin
            m_flag = 1;
            m_cap = cnt;
         end else if (clr_a) begin
            m_flag = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cap_a == m_cap, "R2 model cap", cap_a, m_cap);
         chk(flag_a == m_flag, "R3 model flag", flag_a, m_flag);
         chk(irq_a == (m_flag & ien_a), "R4 model irq", irq_a, m_flag & ien_a);
      end
   end

   initial begin
      #(PER * 200000);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp, c1, c2;
      bit f0;
      // R9: reset state
      wait_n(3);
      chk(cap_a == 0 && flag_a == 0 && irq_a == 0, "R9 reset state",
          {cap_a, flag_a, irq_a}, 0);
      rst_n = 1'b1;
      wait_n(10);

      // R7: exact latency, R2 stored count, R4 no irq when disabled
      sel_a = 2'b01;
      pin_a = 1'b1;
      wait_n(4);
      chk(flag_a == 0, "R7 flag not before edge k+4", flag_a, 0);
      exp = cnt;
      tick();
      chk(flag_a == 1, "R7 flag at edge k+4", flag_a, 1);
      chk(cap_a == exp, "R2 count at capture edge", cap_a, exp);
      chk(irq_a == 0, "R4 flag set with enable low", irq_a, 0);
      ien_a = 1'b1;
      #1;
      chk(irq_a == 1, "R4 irq with flag and enable", irq_a, 1);
      // R8: hold
      c1 = cap_a;
      wait_n(6);
      chk(cap_a == c1 && flag_a == 1, "R8 value and flag hold", cap_a, c1);
      // R3 clear
      clear_a();
      chk(flag_a == 0 && irq_a == 0, "R3 clear strobe", flag_a, 0);
      ien_a = 1'b0;

      // R1: rising-only ignores falling
      pin_a = 1'b0;
      wait_n(8);
      chk(flag_a == 0, "R1 rising select ignores fall", flag_a, 0);
      // R1: falling-only
      sel_a = 2'b10;
      pin_a = 1'b1;
      wait_n(8);
      chk(flag_a == 0, "R1 falling select ignores rise", flag_a, 0);
      pin_a = 1'b0;
      wait_n(8);
      chk(flag_a == 1, "R1 falling select captures fall", flag_a, 1);
      clear_a();
      // R1: off
      sel_a = 2'b00;
      c1 = cap_a;
      pin_a = 1'b1; wait_n(8);
      pin_a = 1'b0; wait_n(8);
      chk(flag_a == 0 && cap_a == c1, "R1 select off no capture", cap_a, c1);
      // R1 both + R2 overwrite
      sel_a = 2'b11;
      pin_a = 1'b1; wait_n(6);
      c1 = cap_a;
      chk(flag_a == 1, "R1 both select rise", flag_a, 1);
      pin_a = 1'b0; wait_n(6);
      c2 = cap_a;
      chk(c2 - c1 == 16'd6, "R2 overwrite by later capture", c2 - c1, 6);
      clear_a();

      // R3: capture wins over clear on same edge
      pin_a = 1'b1;
      wait_n(4);
      clr_a = 1'b1;
      tick();
      clr_a = 1'b0;
      chk(flag_a == 1, "R3 capture beats clear", flag_a, 1);
      wait_n(4);
      clear_a();
      pin_a = 1'b0; wait_n(8);
      clear_a();

      // R5: sub-clock glitch and single-sample pulse
      pin_a = 1'b1; #2; pin_a = 1'b0;
      wait_n(8);
      chk(flag_a == 0, "R5 unsampled glitch ignored", flag_a, 0);
      pin_a = 1'b1; tick(); pin_a = 1'b0;
      wait_n(8);
      chk(flag_a == 0, "R5 one-sample pulse rejected", flag_a, 0);
      // R6: two-sample pulse accepted
      sel_a = 2'b01;
      pin_a = 1'b1; tick(); tick(); pin_a = 1'b0;
      wait_n(10);
      chk(flag_a == 1, "R6 two-sample pulse captured", flag_a, 1);
      clear_a();

      // R10: shared count, independent channels
      pin_a = 1'b1; pin_b = 1'b1;
      wait_n(6);
      chk(cap_a == cap_b && flag_b == 1, "R10 same-edge same count", cap_b, cap_a);
      pin_a = 1'b0; pin_b = 1'b0;
      wait_n(8);
      clear_a();
      pin_a = 1'b1; tick(); pin_b = 1'b1;
      wait_n(6);
      chk(cap_b - cap_a == 16'd1, "R10 one-cycle skew", cap_b - cap_a, 1);
      f0 = flag_b;
      clr_b = 1'b1; tick(); clr_b = 1'b0;
      chk(flag_a == 1 && f0 == 1 && flag_b == 0, "R10 clear is per channel",
          {flag_a, flag_b}, 2'b10);

      // R9: pin high through reset gives no false capture
      sel_a = 2'b11;
      rst_n = 1'b0;
      wait_n(3);
      chk(cap_a == 0 && flag_a == 0 && flag_b == 0, "R9 reset clears state",
          cap_a, 0);
      rst_n = 1'b1;
      wait_n(12);
      chk(flag_a == 0 && flag_b == 0, "R9 no false edge after reset",
          {flag_a, flag_b}, 0);
      pin_a = 1'b0;
      wait_n(8);
      chk(flag_a == 1, "R9 real edge after reset", flag_a, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule